// File: doc/BRIEF.md
# End-Marker Terminated Stream Reader

This block reads a contiguous array of 64-bit elements from a memory whose read latency is long and may vary. It sends the elements downstream on a valid/ready stream. The stream ends at whichever comes first: an element whose low 32-bit word holds the terminator value, or the element-count limit. Read requests are pipelined, so one element per cycle is sustained while many reads are in flight.

The block issues reads speculatively. When the terminating element returns, it stops issuing. Responses already in flight are allowed to arrive and are then dropped. The completion pulse is raised only after the last of those responses has come back.

A credit check bounds the reads in flight plus the elements buffered to the depth of the internal response buffer. A stalled consumer can therefore never overflow the buffer. The host pulses a start with a base address and a maximum element count, then waits for the completion pulse.

Top module: `esr_reader`

## Requirements
- R1: After reset, `rd_req_o`, `out_valid_o`, `busy_o` and `done_o` are all 0.
- R2: A start pulse while idle latches the base address and count. The k-th read request (k counting from 0) carries address base + k*STEP, with STEP = 8 bytes by default. Requests are issued in increasing order.
- R3: When the consumer is always ready and DEPTH exceeds the read latency, requests are issued on consecutive cycles with no gaps until the count is reached.
- R4: Reads in flight plus buffered elements never exceed DEPTH. With the consumer stalled, exactly DEPTH reads are issued and then issuing pauses.
- R5: Elements are forwarded in address order and unchanged. An element whose bits [31:0] equal 0x70000000 is the terminator: it is forwarded with `out_last_o`=1. The same value in bits [63:32] does not terminate the stream.
- R6: No element after the terminator is forwarded. From the cycle after the terminator's response arrives, no new read is requested. Later responses are dropped.
- R7: If no terminator appears among the first `max_count_i` elements, exactly that many elements are forwarded. The last of them carries `out_last_o`=1. No more than `max_count_i` reads are issued.
- R8: `done_o` is a single-cycle pulse. It comes one cycle after two conditions both hold: the last element has been accepted, and every issued read has returned.
- R9: A start with `max_count_i`=0 issues no read and forwards nothing, and still produces one `done_o` pulse.
- R10: A start pulse while `busy_o` is 1 is ignored and does not disturb the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| base_addr_i | input | ADDR_W | Byte address of the first element |
| max_count_i | input | CNT_W | Maximum number of elements to fetch |
| rd_req_o | output | 1 | Read request, accepted by memory every cycle it is high |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_rvalid_i | input | 1 | Read response valid, responses return in request order |
| rd_rdata_i | input | 64 | Read response data |
| out_valid_o | output | 1 | Stream element valid |
| out_data_o | output | 64 | Stream element |
| out_last_o | output | 1 | Marks the final forwarded element |
| out_ready_i | input | 1 | Consumer ready |
| busy_o | output | 1 | Transfer or drain in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A read request is combinational from registered state. The bench therefore samples it in the same cycle, at the falling edge before the clock edge that commits it. A returned response shows up on `out_valid_o` one clock edge after it is presented, and the request gate closes one edge after the terminator's response. The bench checks for forbidden requests from the next falling edge onward. `done_o` is due one edge after the drain completes, so at the falling edge where it is seen, the bench requires every issued read to have been answered already. Consumer transfers are recorded at the falling edge before the edge that takes them, using the ready value just driven.

// File: rtl/esr_pkg.sv
package esr_pkg;
   localparam int ELEM_W = 64;
   localparam int HALF_W = 32;

   typedef logic [ELEM_W-1:0] elem_t;

   typedef struct packed {
      logic  last;
      elem_t data;
   } slot_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_FLUSH = 2'd2
   } phase_t;
endpackage

// File: rtl/esr_fifo.sv
module esr_fifo
   import esr_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_i,
   input  slot_t                      din_i,
   input  logic                       pop_i,
   output slot_t                      dout_o,
   output logic                       empty_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   slot_t          store [DEPTH];
   logic [AW-1:0]  wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CW-1:0]  cnt_q;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_q + AW'(1);
         assign rd_nxt = rd_q + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
         assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_i) store[wr_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wr_q <= wr_nxt;
         if (pop_i)  rd_q <= rd_nxt;
         case ({push_i, pop_i})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout_o  = store[rd_q];
   assign empty_o = (cnt_q == '0);
   assign count_o = cnt_q;

   AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (cnt_q < CW'(DEPTH)) || pop_i); // R4
   AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o); // R5
endmodule

// File: rtl/esr_issue.sv
module esr_issue #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int DEPTH  = 64,
   parameter int STEP   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       launch_i,
   input  logic [ADDR_W-1:0]          base_i,
   input  logic [CNT_W-1:0]           limit_i,
   input  logic                       active_i,
   input  logic                       halt_i,
   input  logic                       resp_i,
   input  logic [$clog2(DEPTH+1)-1:0] buf_cnt_i,
   output logic                       req_o,
   output logic [ADDR_W-1:0]          addr_o,
   output logic [$clog2(DEPTH+1)-1:0] pend_o
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW:0] CAP = (CW+1)'(DEPTH);

   logic [CNT_W-1:0]  issued_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CW-1:0]     pend_q;
   logic [CW:0]       used;
   logic              room;

   assign used  = {1'b0, pend_q} + {1'b0, buf_cnt_i};
   assign room  = (used < CAP);
   assign req_o = active_i && !halt_i && (issued_q < limit_i) && room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issued_q <= '0;
         addr_q   <= '0;
      end else if (launch_i) begin
         issued_q <= '0;
         addr_q   <= base_i;
      end else if (req_o) begin
         issued_q <= issued_q + CNT_W'(1);
         addr_q   <= addr_q + ADDR_W'(STEP);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         case ({req_o, resp_i})
            2'b10:   pend_q <= pend_q + CW'(1);
            2'b01:   pend_q <= pend_q - CW'(1);
            default: pend_q <= pend_q;
         endcase
      end
   end

   assign addr_o = addr_q;
   assign pend_o = pend_q;

   AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, pend_q} + {1'b0, buf_cnt_i}) <= CAP); // R4
   AST_RESP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      resp_i |-> (pend_q != '0)); // R6
endmodule

// File: rtl/esr_filter.sv
module esr_filter
   import esr_pkg::*;
#(
   parameter int          CNT_W  = 16,
   parameter logic [31:0] MARKER = 32'h7000_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             resp_i,
   input  elem_t            rdata_i,
   output logic             push_o,
   output slot_t            slot_o,
   output logic             seen_o
);
   logic [CNT_W-1:0] ret_q;
   logic             seen_q;
   logic             hit, at_end;

   assign hit    = (rdata_i[HALF_W-1:0] == MARKER);
   assign at_end = (ret_q == limit_i - CNT_W'(1));
   assign push_o = resp_i && !seen_q;

   assign slot_o.data = rdata_i;
   assign slot_o.last = hit || at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_q  <= '0;
         seen_q <= 1'b0;
      end else if (launch_i) begin
         ret_q  <= '0;
         seen_q <= 1'b0;
      end else if (push_o) begin
         ret_q <= ret_q + CNT_W'(1);
         if (slot_o.last) seen_q <= 1'b1;
      end
   end

   assign seen_o = seen_q;

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> (ret_q < limit_i)); // R7
endmodule

// File: rtl/esr_reader.sv
module esr_reader
   import esr_pkg::*;
#(
   parameter int          ADDR_W = 32,
   parameter int          CNT_W  = 16,
   parameter int          DEPTH  = 64,
   parameter int          STEP   = 8,
   parameter logic [31:0] MARKER = 32'h7000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [CNT_W-1:0]  max_count_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_rvalid_i,
   input  logic [63:0]       rd_rdata_i,
   output logic              out_valid_o,
   output logic [63:0]       out_data_o,
   output logic              out_last_o,
   input  logic              out_ready_i,
   output logic              busy_o,
   output logic              done_o
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("esr_reader: DEPTH must be at least 2");
      end
      if (STEP < 1) begin : g_bad_step
         $error("esr_reader: STEP must be positive");
      end
      if (CNT_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("esr_reader: widths must be positive");
      end
   endgenerate

   phase_t           phase_q;
   logic [CNT_W-1:0] limit_q;
   logic             done_q;
   logic             launch, pop, active;
   logic             push, seen, empty;
   slot_t            in_slot, head;
   logic [CW-1:0]    buf_cnt, pend;

   assign launch = start_i && (phase_q == ST_IDLE);
   assign active = (phase_q == ST_RUN);
   assign pop    = out_valid_o && out_ready_i;

   esr_issue #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DEPTH  (DEPTH),
      .STEP   (STEP)
   ) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch_i  (launch),
      .base_i    (base_addr_i),
      .limit_i   (limit_q),
      .active_i  (active),
      .halt_i    (seen),
      .resp_i    (rd_rvalid_i),
      .buf_cnt_i (buf_cnt),
      .req_o     (rd_req_o),
      .addr_o    (rd_addr_o),
      .pend_o    (pend)
   );

   esr_filter #(
      .CNT_W  (CNT_W),
      .MARKER (MARKER)
   ) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .limit_i  (limit_q),
      .resp_i   (rd_rvalid_i),
      .rdata_i  (rd_rdata_i),
      .push_o   (push),
      .slot_o   (in_slot),
      .seen_o   (seen)
   );

   esr_fifo #(
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .din_i   (in_slot),
      .pop_i   (pop),
      .dout_o  (head),
      .empty_o (empty),
      .count_o (buf_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= ST_IDLE;
         limit_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            ST_IDLE: begin
               if (start_i) begin
                  limit_q <= max_count_i;
                  phase_q <= (max_count_i == '0) ? ST_FLUSH : ST_RUN;
               end
            end
            ST_RUN: begin
               if (pop && head.last) phase_q <= ST_FLUSH;
            end
            ST_FLUSH: begin
               if (pend == '0) begin
                  done_q  <= 1'b1;
                  phase_q <= ST_IDLE;
               end
            end
            default: phase_q <= ST_IDLE;
         endcase
      end
   end

   assign out_valid_o = !empty;
   assign out_data_o  = head.data;
   assign out_last_o  = head.last;
   assign busy_o      = (phase_q != ST_IDLE);
   assign done_o      = done_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
   AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (pend == '0) && !out_valid_o); // R8
   AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_data_o)); // R5
   AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == ST_IDLE) |-> !rd_rvalid_i || !push); // R6
endmodule

// File: tb/esr_reader_tb.sv
`timescale 1ns/100ps
module esr_reader_tb;
   localparam int ADDR_W = 32;
   localparam int CNT_W  = 16;
   localparam int DEPTH  = 64;
   localparam int STEP   = 8;
   localparam int LAT    = 40;
   localparam int MEMN   = 1024;
   localparam logic [31:0] MARK = 32'h7000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] base_addr_i = '0;
   logic [CNT_W-1:0]  max_count_i = '0;
   logic              rd_req_o;
   logic [ADDR_W-1:0] rd_addr_o;
   logic              rd_rvalid_i = 1'b0;
   logic [63:0]       rd_rdata_i = '0;
   logic              out_valid_o;
   logic [63:0]       out_data_o;
   logic              out_last_o;
   logic              out_ready_i = 1'b0;
   logic              busy_o;
   logic              done_o;

   always #2.5 clk = ~clk;

   esr_reader #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .STEP(STEP)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
      .max_count_i(max_count_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_rvalid_i(rd_rvalid_i), .rd_rdata_i(rd_rdata_i), .out_valid_o(out_valid_o),
      .out_data_o(out_data_o), .out_last_o(out_last_o), .out_ready_i(out_ready_i),
      .busy_o(busy_o), .done_o(done_o)
   );

   logic [63:0] memw [MEMN];
   logic [63:0] rx [$];
   logic [63:0] rq_data [$];
   int          rq_due [$];
   int cyc = 0, total = 0, bad = 0;
   int t_bi = 0, t_base = 0, exp_n = 0, mode = 1, stall_until = 0, last_due = 0;
   int req_cnt = 0, rsp_cnt = 0, done_cnt = 0, addr_err = 0, late_req = 0;
   int last_err = 0, drain_err = 0, done_wide = 0, max_out = 0;
   int first_req_cyc = 0, last_req_cyc = 0;
   bit halted = 0, done_prev = 0, finished = 0;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
      end
   endtask

   function automatic int exp_len(input int bi, input int n);
      for (int i = 0; i < n; i++)
         if (memw[bi+i][31:0] == MARK) return i + 1;
      return n;
   endfunction

   task automatic prep(input int bi, input int span, input int mpos, input bit hi);
      for (int i = 0; i < span; i++) begin
         logic [63:0] w;
         w = {$urandom, $urandom};
         if (w[31:0] == MARK) w[0] = ~w[0];
         memw[bi+i] = w;
      end
      if (mpos >= 0) begin
         if (hi) memw[bi+mpos][63:32] = MARK;
         else    memw[bi+mpos][31:0]  = MARK;
      end
   endtask

   always @(negedge clk) begin
      int d;
      int outst;
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
      if (rst_n) begin
         if (halted && rd_req_o) late_req++;
         if (rd_req_o) begin
            if (rd_addr_o != ADDR_W'(t_base + STEP*req_cnt)) addr_err++;
            if (req_cnt == 0) first_req_cyc = cyc;
            last_req_cyc = cyc;
            d = cyc + LAT + int'($urandom % 4);
            if (d <= last_due) d = last_due + 1;
            last_due = d;
            rq_data.push_back((t_bi + req_cnt < MEMN) ? memw[t_bi+req_cnt] : 64'd0);
            rq_due.push_back(d);
            req_cnt++;
         end
         if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
            rd_rvalid_i = 1'b1;
            rd_rdata_i  = rq_data.pop_front();
            void'(rq_due.pop_front());
            if (rsp_cnt == exp_n - 1) halted = 1;
            rsp_cnt++;
         end else begin
            rd_rvalid_i = 1'b0;
            rd_rdata_i  = '0;
         end
         case (mode)
            0:       out_ready_i = (($urandom % 4) != 0);
            2:       out_ready_i = (cyc >= stall_until);
            default: out_ready_i = 1'b1;
         endcase
         if (out_valid_o && out_ready_i) begin
            rx.push_back(out_data_o);
            if (out_last_o != (rx.size() == exp_n)) last_err++;
         end
         outst = req_cnt - rx.size();
         if (outst > max_out) max_out = outst;
         if (done_o) begin
            done_cnt++;
            if (req_cnt != rsp_cnt) drain_err++;
            if (done_prev) done_wide++;
         end
         done_prev = done_o;
      end
   end

   task automatic run(input int bi, input int n, input int md, input int stall,
                      input int extra, input string tag);
      int w, mism;
      t_bi = bi; t_base = bi * STEP; exp_n = exp_len(bi, n);
      req_cnt = 0; rsp_cnt = 0; done_cnt = 0; addr_err = 0; late_req = 0;
      last_err = 0; drain_err = 0; done_wide = 0; max_out = 0; halted = 0;
      rx.delete(); mode = md; stall_until = cyc + stall;
      @(negedge clk);
      start_i = 1'b1; base_addr_i = ADDR_W'(t_base); max_count_i = CNT_W'(n);
      @(negedge clk);
      start_i = 1'b0; base_addr_i = 32'h0000_4440; max_count_i = CNT_W'(3);
      if (extra > 0) begin
         repeat (extra) @(negedge clk);
         start_i = 1'b1; base_addr_i = 32'h0000_1000; max_count_i = CNT_W'(5);
         @(negedge clk);
         start_i = 1'b0;
      end
      w = 0;
      while (done_cnt == 0 && w < 20000) begin
         @(negedge clk);
         w++;
      end
      repeat (12) @(negedge clk);
      mism = 0;
      for (int i = 0; i < rx.size() && i < exp_n; i++)
         if (rx[i] != memw[bi+i]) mism++;
      check(rx.size() == exp_n, {tag, " R6 R7 element count"}, rx.size(), exp_n);
      check(mism == 0, {tag, " R5 data order"}, mism, 0);
      check(last_err == 0, {tag, " R5 last flag"}, last_err, 0);
      check(addr_err == 0, {tag, " R2 addresses"}, addr_err, 0);
      check(late_req == 0, {tag, " R6 no read after terminator"}, late_req, 0);
      check(req_cnt <= n, {tag, " R7 read limit"}, req_cnt, n);
      check(done_cnt == 1 && done_wide == 0, {tag, " R8 done pulse"}, done_cnt, 1);
      check(drain_err == 0, {tag, " R8 drained at done"}, drain_err, 0);
      check(max_out <= DEPTH, {tag, " R4 credit bound"}, max_out, DEPTH);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (5) @(negedge clk);
      check(rd_req_o == 1'b0, "R1 rd_req_o", rd_req_o, 0);
      check(out_valid_o == 1'b0, "R1 out_valid_o", out_valid_o, 0);
      check(done_o == 1'b0, "R1 done_o", done_o, 0);
      check(busy_o == 1'b0, "R1 busy_o", busy_o, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      prep(10, 30, 5, 0);   run(10, 20, 1, 0, 0, "mark5");
      prep(50, 40, -1, 0);  run(50, 30, 0, 0, 0, "nomark");
      prep(100, 20, 0, 0);  run(100, 10, 0, 0, 0, "mark0");
      prep(130, 20, 11, 0); run(130, 12, 1, 0, 0, "markN-1");
      prep(160, 20, 8, 0);  run(160, 8, 0, 0, 0, "markN");
      prep(180, 20, 3, 1);  run(180, 10, 1, 0, 0, "R5 highword");
      check(rx.size() == 10, "R5 high word ignored", rx.size(), 10);
      prep(200, 4, -1, 0);  run(200, 0, 1, 0, 0, "R9 zero");
      check(req_cnt == 0, "R9 no reads", req_cnt, 0);
      prep(210, 4, -1, 0);  run(210, 1, 0, 0, 0, "one");
      prep(300, 160, -1, 0); run(300, 150, 1, 0, 0, "R3 rate");
      check(last_req_cyc - first_req_cyc == 149, "R3 back-to-back reads",
            last_req_cyc - first_req_cyc, 149);
      prep(500, 160, -1, 0); run(500, 150, 2, 300, 0, "R4 stall");
      check(max_out == DEPTH, "R4 stall stops at depth", max_out, DEPTH);
      prep(700, 60, 45, 0); run(700, 50, 0, 0, 20, "R10 restart");
      check(rx.size() == 46, "R10 restart ignored", rx.size(), 46);

      for (int k = 0; k < 8; k++) begin
         int bi, n, mp;
         bi = int'($urandom % 600);
         n  = 1 + int'($urandom % 120);
         mp = (($urandom % 3) == 0) ? -1 : int'($urandom % (n + 5));
         prep(bi, n + 8, mp, 0);
         run(bi, n, int'($urandom % 2), 0, 0, "random");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule